// File: doc/BRIEF.md
# Speculative Load-Hit Wakeup Scheduler

This block is a small out-of-order issue queue. Each tracked instruction names a destination tag and two source tags. The queue picks at most one instruction per cycle, the oldest of those whose sources are ready. When an operation issues, the queue schedules the wakeup of its own destination tag. The timing of that wakeup depends on the operation class, so that a dependent can go out in the very cycle the result becomes usable.

Loads are treated as if they always hit the data cache. Their dependents are woken at the hit latency and marked speculative against the load's tag. One cycle later a hit/miss status for that tag arrives. A hit clears the speculative marks. A miss cancels every dependent that issued on the guess and drops its ready bit. The cancelled dependent stays in the queue until a fill for that tag reports that the data is present, and then it issues again.

Renaming, execution and register storage lie outside the block. The environment dispatches instructions with source readiness already resolved, reports load status, and broadcasts fills.

Top module: `wsched_top`

## Requirements
- R1: Among entries whose two sources are ready and that have not yet issued, the entry dispatched earliest is issued, at most one per cycle, regardless of which slot it occupies.
- R2: An operation of kind 0 (single-cycle) wakes its dependents in its issue cycle, so a dependent issues in the next cycle, even when that dependent is dispatched in the producer's issue cycle.
- R3: An operation of kind 1 (multi-cycle, latency MUL_LAT) wakes dependents MUL_LAT-1 cycles after issue, so a dependent issues exactly MUL_LAT cycles after the producer.
- R4: An operation of kind 2 (load) wakes dependents speculatively LD_LAT-1 cycles after issue, so a dependent issues exactly LD_LAT cycles after the load. A hit status for the load's tag confirms it.
- R5: A miss status for a load's tag, arriving LD_LAT cycles after the load issued, cancels every dependent woken on that guess. A dependent issued in that cycle produces no wakeup of its own.
- R6: A cancelled dependent does not issue again until a fill for the load's tag is seen. It then issues in the following cycle, and its own dependents follow.
- R7: When every slot is occupied, `full` is 1 and a dispatch is ignored.
- R8: After reset the queue is empty: `issue_valid` is 0 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_kind | input | 2 | 0 single-cycle, 1 multi-cycle, 2 load |
| disp_dst | input | TAG_W | Destination tag |
| disp_src0 | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| lst_valid | input | 1 | Load status present |
| lst_hit | input | 1 | 1 hit, 0 miss |
| lst_tag | input | TAG_W | Destination tag of the reported load |
| fill_valid | input | 1 | Miss data has arrived |
| fill_tag | input | TAG_W | Tag whose data arrived |
| full | output | 1 | All slots occupied |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_kind | output | 2 | Kind of the issued instruction |
| issue_dst | output | TAG_W | Destination tag of the issued instruction |
| issue_src0 | output | TAG_W | First source tag of the issued instruction |
| issue_src1 | output | TAG_W | Second source tag of the issued instruction |

## Verification
The bench instantiates the block with four slots, four-bit tags and three-cycle latencies for both the multi-cycle class and the load hit. Four slots let the queue fill after four dispatches, so the ignored fifth dispatch can be observed at the issue port. Three-cycle latencies leave two silent cycles between producer and dependent, which exposes a wakeup that arrives one cycle early or late. With so few slots, slot reuse also places an older entry above a younger one, which tests age ordering.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
   typedef enum logic [1:0] {
      OP_ALU  = 2'd0,
      OP_MUL  = 2'd1,
      OP_LOAD = 2'd2
   } op_kind_e;
endpackage

// File: rtl/wsched_pick.sv
module wsched_pick #(
   parameter int DEPTH = 8,
   parameter int AGE_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DEPTH-1:0]            req,
   input  logic [DEPTH-1:0][AGE_W-1:0] age,
   output logic [DEPTH-1:0]            grant
);
   logic             found;
   logic [AGE_W-1:0] best;

   always_comb begin
      found = 1'b0;
      best  = '0;
      grant = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (req[i] && (!found || age[i] < best)) begin
            found = 1'b1;
            best  = age[i];
            grant = '0;
            grant[i] = 1'b1;
         end
      end
   end

   // R1: single grant, only to a requester
   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/wsched_slot.sv
module wsched_slot
   import wsched_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int TAG_W   = 6,
   parameter int AGE_W   = 3,
   parameter int MUL_LAT = 3,
   parameter int LD_LAT  = 4,
   parameter int TMR_W   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        alloc,
   input  op_kind_e                    in_kind,
   input  logic [TAG_W-1:0]            in_dst,
   input  logic [1:0][TAG_W-1:0]       in_src,
   input  logic [1:0]                  in_rdy,
   input  logic [AGE_W-1:0]            in_age,
   input  logic                        grant,
   input  logic [AGE_W-1:0]            age_dec,
   input  logic [DEPTH-1:0]            bc_v_all,
   input  logic [DEPTH-1:0][TAG_W-1:0] bc_tag_all,
   input  logic [DEPTH-1:0]            bc_spec_all,
   input  logic                        st_v,
   input  logic                        st_hit,
   input  logic [TAG_W-1:0]            st_tag,
   input  logic                        fl_v,
   input  logic [TAG_W-1:0]            fl_tag,
   output logic                        vld_o,
   output logic                        req_o,
   output logic [AGE_W-1:0]            age_o,
   output logic                        free_o,
   output logic                        bc_v_o,
   output logic                        bc_spec_o,
   output logic [TAG_W-1:0]            dst_o,
   output op_kind_e                    kind_o,
   output logic [1:0][TAG_W-1:0]       src_o
);
   logic                  vld_q, iss_q;
   op_kind_e              kind_q;
   logic [TAG_W-1:0]      dst_q;
   logic [1:0][TAG_W-1:0] src_q, cmp;
   logic [1:0]            rdy_q, spc_q, wk, wks, miss, hclr;
   logic [TMR_W-1:0]      tmr_q, lat, lat_m1;
   logic [AGE_W-1:0]      age_q;
   logic                  squash, timed_bc;

   always_comb begin
      case (kind_q)
         OP_MUL:  lat = TMR_W'(MUL_LAT);
         OP_LOAD: lat = TMR_W'(LD_LAT);
         default: lat = TMR_W'(1);
      endcase
      lat_m1 = lat - TMR_W'(1);
   end

   always_comb begin
      for (int k = 0; k < 2; k++) begin
         cmp[k] = alloc ? in_src[k] : src_q[k];
         wk[k]  = 1'b0;
         wks[k] = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (bc_v_all[j] && bc_tag_all[j] == cmp[k]) begin
               wk[k]  = 1'b1;
               wks[k] = bc_spec_all[j];
            end
         end
         if (fl_v && fl_tag == cmp[k]) begin
            wk[k]  = 1'b1;
            wks[k] = 1'b0;
         end
         miss[k] = st_v && !st_hit && spc_q[k] && src_q[k] == st_tag;
         hclr[k] = st_v && st_hit && spc_q[k] && src_q[k] == st_tag;
      end
   end

   assign squash   = vld_q && (|miss);
   assign timed_bc = iss_q && (lat != TMR_W'(1)) && (tmr_q == lat_m1);
   assign bc_v_o   = vld_q && !squash && ((grant && lat == TMR_W'(1)) || timed_bc);
   assign bc_spec_o = (kind_q == OP_LOAD);
   assign req_o    = vld_q && !iss_q && (&rdy_q);
   assign free_o   = vld_q && iss_q && !squash &&
                     ((kind_q == OP_LOAD) ? (st_v && st_tag == dst_q)
                                          : (tmr_q >= lat_m1 && tmr_q != '0 &&
                                             ((spc_q & ~hclr) == 2'b00)));
   assign vld_o  = vld_q;
   assign age_o  = age_q;
   assign dst_o  = dst_q;
   assign kind_o = kind_q;
   assign src_o  = src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         iss_q  <= 1'b0;
         kind_q <= OP_ALU;
         dst_q  <= '0;
         src_q  <= '0;
         rdy_q  <= '0;
         spc_q  <= '0;
         tmr_q  <= '0;
         age_q  <= '0;
      end else if (alloc) begin
         vld_q  <= 1'b1;
         iss_q  <= 1'b0;
         kind_q <= in_kind;
         dst_q  <= in_dst;
         src_q  <= in_src;
         rdy_q  <= in_rdy | wk;
         spc_q  <= ~in_rdy & wk & wks;
         tmr_q  <= '0;
         age_q  <= in_age;
      end else if (vld_q) begin
         if (free_o) begin
            vld_q <= 1'b0;
            iss_q <= 1'b0;
         end else begin
            age_q <= age_q - age_dec;
            for (int k = 0; k < 2; k++) begin
               if (miss[k]) begin
                  rdy_q[k] <= 1'b0;
                  spc_q[k] <= 1'b0;
               end else if (hclr[k]) begin
                  spc_q[k] <= 1'b0;
               end else if (!rdy_q[k] && wk[k]) begin
                  rdy_q[k] <= 1'b1;
                  spc_q[k] <= wks[k];
               end
            end
            if (squash) begin
               iss_q <= 1'b0;
               tmr_q <= '0;
            end else if (grant) begin
               iss_q <= 1'b1;
               tmr_q <= TMR_W'(1);
            end else if (iss_q && tmr_q != lat) begin
               tmr_q <= tmr_q + TMR_W'(1);
            end
         end
      end
   end

   // R4: a speculative mark only exists on a ready source
   assert_spec_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_q & ~rdy_q) == 2'b00);
   // R5: a cancelled entry is back to not-issued
   assert_squash_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (vld_q && !iss_q));
endmodule

// File: rtl/wsched_top.sv
module wsched_top
   import wsched_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int TAG_W   = 6,
   parameter int MUL_LAT = 3,
   parameter int LD_LAT  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [1:0]       disp_kind,
   input  logic [TAG_W-1:0] disp_dst,
   input  logic [TAG_W-1:0] disp_src0,
   input  logic             disp_src0_rdy,
   input  logic [TAG_W-1:0] disp_src1,
   input  logic             disp_src1_rdy,
   input  logic             lst_valid,
   input  logic             lst_hit,
   input  logic [TAG_W-1:0] lst_tag,
   input  logic             fill_valid,
   input  logic [TAG_W-1:0] fill_tag,
   output logic             full,
   output logic             issue_valid,
   output logic [1:0]       issue_kind,
   output logic [TAG_W-1:0] issue_dst,
   output logic [TAG_W-1:0] issue_src0,
   output logic [TAG_W-1:0] issue_src1
);
   localparam int AGE_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam int MAXL  = (MUL_LAT > LD_LAT) ? MUL_LAT : LD_LAT;
   localparam int TMR_W = $clog2(MAXL + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("wsched_top: DEPTH must be at least 2");
   end
   if (MUL_LAT < 2 || LD_LAT < 2) begin : g_bad_lat
      $error("wsched_top: multi-cycle and load latencies must be at least 2");
   end

   logic [DEPTH-1:0]              vld, req, grant, freev, alloc, bc_v, bc_spec;
   logic [DEPTH-1:0][AGE_W-1:0]   age, age_dec;
   logic [DEPTH-1:0][TAG_W-1:0]   dst, bc_tag;
   logic [DEPTH-1:0][1:0][TAG_W-1:0] src;
   op_kind_e                      kind [DEPTH];
   logic [AGE_W-1:0]              new_age;
   logic [1:0][TAG_W-1:0]         in_src;
   logic [1:0]                    in_rdy;

   assign full    = &vld;
   assign in_src  = {disp_src1, disp_src0};
   assign in_rdy  = {disp_src1_rdy, disp_src0_rdy};
   assign new_age = AGE_W'($countones(vld & ~freev));
   assign bc_tag  = dst;

   always_comb begin
      alloc = '0;
      if (disp_valid && !full) begin
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
               alloc = '0;
               alloc[i] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         age_dec[i] = '0;
         for (int j = 0; j < DEPTH; j++) begin
            if (freev[j] && age[j] < age[i]) age_dec[i] = age_dec[i] + AGE_W'(1);
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      wsched_slot #(
         .DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W),
         .MUL_LAT(MUL_LAT), .LD_LAT(LD_LAT), .TMR_W(TMR_W)
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .alloc(alloc[g]),
         .in_kind(op_kind_e'(disp_kind)), .in_dst(disp_dst),
         .in_src(in_src), .in_rdy(in_rdy), .in_age(new_age),
         .grant(grant[g]), .age_dec(age_dec[g]),
         .bc_v_all(bc_v), .bc_tag_all(bc_tag), .bc_spec_all(bc_spec),
         .st_v(lst_valid), .st_hit(lst_hit), .st_tag(lst_tag),
         .fl_v(fill_valid), .fl_tag(fill_tag),
         .vld_o(vld[g]), .req_o(req[g]), .age_o(age[g]), .free_o(freev[g]),
         .bc_v_o(bc_v[g]), .bc_spec_o(bc_spec[g]), .dst_o(dst[g]),
         .kind_o(kind[g]), .src_o(src[g])
      );
   end

   wsched_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(req), .age(age), .grant(grant)
   );

   always_comb begin
      issue_valid = |grant;
      issue_kind  = '0;
      issue_dst   = '0;
      issue_src0  = '0;
      issue_src1  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) begin
            issue_kind = kind[i];
            issue_dst  = dst[i];
            issue_src0 = src[i][0];
            issue_src1 = src[i][1];
         end
      end
   end

   // checking aids: older requester present, duplicated age among live slots
   logic [DEPTH-1:0] older_req;
   logic             age_dup;
   always_comb begin
      age_dup = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         older_req[i] = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && req[j] && age[j] < age[i]) older_req[i] = 1'b1;
            if (j != i && vld[i] && vld[j] && age[i] == age[j]) age_dup = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R1: the winner has no older ready competitor
      assert_oldest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
         grant[g] |-> !older_req[g]);
   end
   // R1: live slots hold distinct age ranks
   assert_age_unique_R1: assert property (@(posedge clk) disable iff (!rst_n) !age_dup);
   // R7: no slot is claimed while the queue is full
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> alloc == '0);
endmodule

// File: tb/wsched_top_bench.sv
module wsched_top_bench;
   localparam int TW = 4;

   typedef struct packed {
      logic          dv;
      logic [1:0]    dk;
      logic [TW-1:0] dd;
      logic [TW-1:0] ds;
      logic          dr;
      logic          sv;
      logic          sh;
      logic [TW-1:0] st;
      logic          fv;
      logic [TW-1:0] ft;
      logic          ev;
      logic [TW-1:0] ed;
   } row_t;

   localparam int NROW = 37;
   localparam row_t TBL [NROW] = '{
      // R2: single-cycle chain
      '{1'b1, 2'd0, 4'd1,  4'd0,  1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd2,  4'd1,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd1},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd2},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      // R3: multi-cycle producer
      '{1'b1, 2'd1, 4'd3,  4'd0,  1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd4,  4'd3,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd3},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd4},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      // R1: older entry in a higher slot wins
      '{1'b1, 2'd0, 4'd5,  4'd11, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd6,  4'd10, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 4'd11, 1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd5},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd7,  4'd10, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 4'd10, 1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd6},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd7},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      // R4: load hit, speculative dependent
      '{1'b1, 2'd2, 4'd9,  4'd0,  1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd10, 4'd9,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd9},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b1, 1'b1, 4'd9,  1'b0, 4'd0,  1'b1, 4'd10},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      // R5: load miss cancels dependent and its wakeup
      '{1'b1, 2'd2, 4'd11, 4'd0,  1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b1, 2'd0, 4'd12, 4'd11, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd11},
      '{1'b1, 2'd0, 4'd13, 4'd12, 1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b1, 1'b0, 4'd11, 1'b0, 4'd0,  1'b1, 4'd12},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      // R6: replay only after the fill
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 4'd11, 1'b0, 4'd0},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd12},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 4'd13},
      '{1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0, disp_src0_rdy = 1'b0, disp_src1_rdy = 1'b1;
   logic [1:0]    disp_kind = '0;
   logic [TW-1:0] disp_dst = '0, disp_src0 = '0, disp_src1 = '0;
   logic          lst_valid = 1'b0, lst_hit = 1'b0, fill_valid = 1'b0;
   logic [TW-1:0] lst_tag = '0, fill_tag = '0;
   logic          full, issue_valid;
   logic [1:0]    issue_kind;
   logic [TW-1:0] issue_dst, issue_src0, issue_src1;
   int            n_chk = 0, n_err = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   wsched_top #(.DEPTH(4), .TAG_W(TW), .MUL_LAT(3), .LD_LAT(3)) u_wsched_top (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dst(disp_dst),
      .disp_src0(disp_src0), .disp_src0_rdy(disp_src0_rdy),
      .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
      .lst_valid(lst_valid), .lst_hit(lst_hit), .lst_tag(lst_tag),
      .fill_valid(fill_valid), .fill_tag(fill_tag),
      .full(full), .issue_valid(issue_valid), .issue_kind(issue_kind),
      .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1)
   );

   task automatic check(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // issue port as one number: 0 when idle, 16+dst when issuing
   function automatic int port_val();
      return issue_valid ? (16 + int'(issue_dst)) : 0;
   endfunction

   function automatic string rq_of(input int k);
      if (k < 4)  return "R2";
      if (k < 10) return "R3";
      if (k < 20) return "R1";
      if (k < 26) return "R4";
      if (k < 32) return "R5";
      return "R6";
   endfunction

   task automatic drive(input row_t r);
      disp_valid    = r.dv;
      disp_kind     = r.dk;
      disp_dst      = r.dd;
      disp_src0     = r.ds;
      disp_src0_rdy = r.dr;
      disp_src1     = '0;
      disp_src1_rdy = 1'b1;
      lst_valid     = r.sv;
      lst_hit       = r.sh;
      lst_tag       = r.st;
      fill_valid    = r.fv;
      fill_tag      = r.ft;
   endtask

   function automatic row_t mk(input logic dv, input logic [TW-1:0] dd,
                               input logic [TW-1:0] ds, input logic dr,
                               input logic fv, input logic [TW-1:0] ft);
      row_t r;
      r    = '0;
      r.dv = dv; r.dd = dd; r.ds = ds; r.dr = dr; r.fv = fv; r.ft = ft;
      return r;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < NROW; k++) begin
         @(negedge clk);
         check(rq_of(k), $sformatf("issue port row %0d", k), port_val(),
               TBL[k].ev ? 16 + int'(TBL[k].ed) : 0);
         drive(TBL[k]);
      end

      // R8: reset state
      @(negedge clk);
      drive('0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", "issue_valid in reset", int'(issue_valid), 0);
      check("R8", "full in reset", int'(full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8", "issue_valid after reset", int'(issue_valid), 0);
      check("R8", "full after reset", int'(full), 0);

      // R7: fill all four slots with entries waiting on tag 15
      for (int d = 1; d <= 4; d++) begin
         drive(mk(1'b1, TW'(d), 4'd15, 1'b0, 1'b0, 4'd0));
         @(negedge clk);
         check("R7", "no issue while waiting", port_val(), 0);
      end
      check("R7", "full with four entries", int'(full), 1);
      drive(mk(1'b1, 4'd14, 4'd0, 1'b1, 1'b0, 4'd0));
      @(negedge clk);
      check("R7", "ignored dispatch does not issue", port_val(), 0);
      drive(mk(1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 4'd15));
      @(negedge clk);
      drive('0);
      for (int d = 1; d <= 4; d++) begin
         check("R7", "release order after fill", port_val(), 16 + d);
         @(negedge clk);
      end
      check("R7", "ignored dispatch never issues", port_val(), 0);
      @(negedge clk);
      check("R7", "still idle", port_val(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule